// File: doc/BRIEF.md
# Replica Result Commit Voter

This block sits between the execute stage and writeback of a wide-issue datapath that runs every instruction two or three times for fault tolerance. Each cycle it receives a set of per-slot results, each with a valid bit and an instruction tag. It also receives a commit configuration from the scheduling controller. For every voter lane, that configuration names where each copy of one instruction comes from: a live execute slot or an entry of a small holding store. A mode input chooses between pairing two copies and voting on three.

Copies of one instruction may finish in different cycles. The controller can therefore ask for any live result to be parked in the holding store. A later cycle then points a voter lane at that entry, once the partner copy arrives. A lane commits only when every copy it needs is present and all of them carry the same tag. The commit consumes the held entries it used. The committed value, its tag, a mismatch flag and a no-majority flag appear registered, one clock after the inputs.

Top module: `commit_voter`

## Requirements
- R1: A synchronous active-high reset clears every commit output and empties the holding store. A lane that points at a holding entry right after reset does not commit.
- R2: With mode = 0 (pairing), a lane whose two copies (copy positions 0 and 1) agree commits copy 0's value and tag with the error flag low.
- R3: With mode = 0, a lane whose two copies differ commits copy 0's value with the error flag high.
- R4: With mode = 1 (three-way vote), a lane commits the value held by at least two of its three copies. The error flag is high when any copy differs, and the no-majority flag stays low.
- R5: With mode = 1, if all three copies differ, the lane commits copy 0's value with both the error and no-majority flags high.
- R6: A slot with its store enable set and a valid result writes its data and tag into the holding entry named by its store index. Later cycles can select that entry as a copy source (source bit 1 = holding store, 0 = execute slot).
- R7: A commit clears every holding entry it used as a copy source, so selecting that entry again does not commit.
- R8: A lane commits only if each needed copy is present and all tags are equal: a valid execute slot, or a valid holding entry. Otherwise its valid, error and no-majority outputs stay low and the holding entries it names are kept.
- R9: Commit outputs are registered and appear on the clock edge after the inputs. A lane with its enable low never commits.
- R10: A holding entry that is consumed and written in the same cycle ends up valid, holding the newly written result.
- R11: In mode = 0 the third copy's configuration is ignored, and the no-majority flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = pair two copies, 1 = vote on three |
| resValid | input | SLOTS | Valid bit per execute slot |
| resData | input | SLOTS*DW | Result data per execute slot |
| resTag | input | SLOTS*TW | Instruction tag per execute slot |
| cfgEn | input | VOTERS | Commit request per voter lane |
| cfgSrc | input | VOTERS*3 | Per lane and copy: 1 = holding store, 0 = execute slot |
| cfgIdx | input | VOTERS*3*IDXW | Per lane and copy: slot or entry index |
| storeEn | input | SLOTS | Park this slot's result in the holding store |
| storeIdx | input | SLOTS*IDXW | Holding entry index for each slot |
| cmtValid | output | VOTERS | Lane committed this cycle |
| cmtData | output | VOTERS*DW | Committed value |
| cmtTag | output | VOTERS*TW | Committed instruction tag |
| cmtErr | output | VOTERS | Copies disagreed |
| cmtNoMaj | output | VOTERS | Three-way vote found no majority |

## Verification
The bench builds the block with its default values: four execute slots, four holding entries, two voter lanes, 16-bit data and 4-bit tags. With only four slots and entries, random index choices often collide, so lanes often name the same source or an empty entry. The bench draws data from four values and tags from two, so agreement, two-of-three majorities, total disagreement and tag mismatch all occur often. Stores that rotate over the entries often land on an entry that a lane is consuming in the same cycle.

// File: rtl/cv_pkg.sv
`timescale 1ns/1ps
package cv_pkg;
  localparam int SLOTS  = 4;
  localparam int HOLD   = 4;
  localparam int VOTERS = 2;
  localparam int DW     = 16;
  localparam int TW     = 4;
  localparam int COPIES = 3;
  localparam int IDXW   = $clog2((SLOTS > HOLD) ? SLOTS : HOLD);

  typedef struct packed {
    logic [VOTERS-1:0] fire;
    logic [HOLD-1:0]   clr;
    logic [HOLD-1:0]   wr;
  } strobe_t;
endpackage

// File: rtl/cv_vote.sv
`timescale 1ns/1ps
module cv_vote import cv_pkg::*; (
  input  logic          mode,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] val,
  output logic          err,
  output logic          noMaj
);
  logic eqAB, eqAC, eqBC;
  assign eqAB = (a == b);
  assign eqAC = (a == c);
  assign eqBC = (b == c);

  always_comb begin
    val   = a;
    err   = 1'b0;
    noMaj = 1'b0;
    if (!mode) begin
      err = !eqAB;
    end else begin
      err = !(eqAB && eqAC);
      if (!eqAB && !eqAC && eqBC) val = b;
      noMaj = !eqAB && !eqAC && !eqBC;
    end
  end
endmodule

// File: rtl/cv_ctrl.sv
`timescale 1ns/1ps
module cv_ctrl import cv_pkg::*; (
  input  logic                          mode,
  input  logic [SLOTS-1:0]              resValid,
  input  logic [SLOTS*TW-1:0]           resTag,
  input  logic [VOTERS-1:0]             cfgEn,
  input  logic [VOTERS*COPIES-1:0]      cfgSrc,
  input  logic [VOTERS*COPIES*IDXW-1:0] cfgIdx,
  input  logic [SLOTS-1:0]              storeEn,
  input  logic [SLOTS*IDXW-1:0]         storeIdx,
  input  logic [HOLD-1:0]               holdValid,
  input  logic [HOLD*TW-1:0]            holdTag,
  output strobe_t                       stb
);
  localparam int NCP = VOTERS * COPIES;

  logic [NCP-1:0] cpPres;
  logic [TW-1:0]  cpTag [NCP];
  logic [VOTERS-1:0] ready;

  for (genvar k = 0; k < NCP; k++) begin : g_copy
    logic [IDXW-1:0] idx;
    assign idx      = cfgIdx[k*IDXW +: IDXW];
    assign cpPres[k] = cfgSrc[k] ? holdValid[idx] : resValid[idx];
    assign cpTag[k]  = cfgSrc[k] ? holdTag[idx*TW +: TW] : resTag[idx*TW +: TW];
  end

  for (genvar v = 0; v < VOTERS; v++) begin : g_lane
    logic pairOk, thirdOk;
    assign pairOk  = cpPres[v*COPIES] && cpPres[v*COPIES+1] &&
                     (cpTag[v*COPIES] == cpTag[v*COPIES+1]);
    assign thirdOk = cpPres[v*COPIES+2] && (cpTag[v*COPIES+2] == cpTag[v*COPIES]);
    assign ready[v] = pairOk && (!mode || thirdOk);
  end

  always_comb begin
    stb      = '0;
    stb.fire = cfgEn & ready;
    for (int v = 0; v < VOTERS; v++) begin
      for (int c = 0; c < COPIES; c++) begin
        if (stb.fire[v] && cfgSrc[v*COPIES+c] && (c < 2 || mode))
          stb.clr[cfgIdx[(v*COPIES+c)*IDXW +: IDXW]] = 1'b1;
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (storeEn[s] && resValid[s]) stb.wr[storeIdx[s*IDXW +: IDXW]] = 1'b1;
    end
  end
endmodule

// File: rtl/cv_dpath.sv
`timescale 1ns/1ps
module cv_dpath import cv_pkg::*; (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode,
  input  logic [SLOTS-1:0]              resValid,
  input  logic [SLOTS*DW-1:0]           resData,
  input  logic [SLOTS*TW-1:0]           resTag,
  input  logic [VOTERS*COPIES-1:0]      cfgSrc,
  input  logic [VOTERS*COPIES*IDXW-1:0] cfgIdx,
  input  logic [SLOTS-1:0]              storeEn,
  input  logic [SLOTS*IDXW-1:0]         storeIdx,
  input  strobe_t                       stb,
  output logic [HOLD-1:0]               holdValid,
  output logic [HOLD*TW-1:0]            holdTag,
  output logic [VOTERS-1:0]             cmtValid,
  output logic [VOTERS*DW-1:0]          cmtData,
  output logic [VOTERS*TW-1:0]          cmtTag,
  output logic [VOTERS-1:0]             cmtErr,
  output logic [VOTERS-1:0]             cmtNoMaj
);
  localparam int NCP = VOTERS * COPIES;

  logic [DW-1:0] hd [HOLD];
  logic [TW-1:0] ht [HOLD];
  logic [DW-1:0] wrData [HOLD];
  logic [TW-1:0] wrTag  [HOLD];
  logic [DW-1:0] cpData [NCP];

  for (genvar h = 0; h < HOLD; h++) begin : g_htag
    assign holdTag[h*TW +: TW] = ht[h];
  end

  always_comb begin
    for (int h = 0; h < HOLD; h++) begin
      wrData[h] = '0;
      wrTag[h]  = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (storeEn[s] && resValid[s] && (int'(storeIdx[s*IDXW +: IDXW]) == h)) begin
          wrData[h] = resData[s*DW +: DW];
          wrTag[h]  = resTag[s*TW +: TW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdValid <= '0;
      for (int h = 0; h < HOLD; h++) begin
        hd[h] <= '0;
        ht[h] <= '0;
      end
    end else begin
      for (int h = 0; h < HOLD; h++) begin
        if (stb.wr[h]) begin
          holdValid[h] <= 1'b1;
          hd[h]        <= wrData[h];
          ht[h]        <= wrTag[h];
        end else if (stb.clr[h]) begin
          holdValid[h] <= 1'b0;
        end
      end
    end
  end

  for (genvar k = 0; k < NCP; k++) begin : g_mux
    logic [IDXW-1:0] idx;
    assign idx       = cfgIdx[k*IDXW +: IDXW];
    assign cpData[k] = cfgSrc[k] ? hd[idx] : resData[idx*DW +: DW];
  end

  for (genvar v = 0; v < VOTERS; v++) begin : g_lane
    logic [DW-1:0]   val;
    logic            err, noMaj;
    logic [IDXW-1:0] idx0;
    logic [TW-1:0]   tag0;
    assign idx0 = cfgIdx[v*COPIES*IDXW +: IDXW];
    assign tag0 = cfgSrc[v*COPIES] ? ht[idx0] : resTag[idx0*TW +: TW];

    cv_vote u_vote (
      .mode (mode),
      .a    (cpData[v*COPIES]),
      .b    (cpData[v*COPIES+1]),
      .c    (cpData[v*COPIES+2]),
      .val  (val),
      .err  (err),
      .noMaj(noMaj)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        cmtValid[v]            <= 1'b0;
        cmtData[v*DW +: DW]    <= '0;
        cmtTag[v*TW +: TW]     <= '0;
        cmtErr[v]              <= 1'b0;
        cmtNoMaj[v]            <= 1'b0;
      end else begin
        cmtValid[v]            <= stb.fire[v];
        cmtData[v*DW +: DW]    <= stb.fire[v] ? val  : '0;
        cmtTag[v*TW +: TW]     <= stb.fire[v] ? tag0 : '0;
        cmtErr[v]              <= stb.fire[v] && err;
        cmtNoMaj[v]            <= stb.fire[v] && noMaj;
      end
    end
  end
endmodule

// File: rtl/commit_voter.sv
`timescale 1ns/1ps
module commit_voter import cv_pkg::*; (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode,
  input  logic [SLOTS-1:0]              resValid,
  input  logic [SLOTS*DW-1:0]           resData,
  input  logic [SLOTS*TW-1:0]           resTag,
  input  logic [VOTERS-1:0]             cfgEn,
  input  logic [VOTERS*COPIES-1:0]      cfgSrc,
  input  logic [VOTERS*COPIES*IDXW-1:0] cfgIdx,
  input  logic [SLOTS-1:0]              storeEn,
  input  logic [SLOTS*IDXW-1:0]         storeIdx,
  output logic [VOTERS-1:0]             cmtValid,
  output logic [VOTERS*DW-1:0]          cmtData,
  output logic [VOTERS*TW-1:0]          cmtTag,
  output logic [VOTERS-1:0]             cmtErr,
  output logic [VOTERS-1:0]             cmtNoMaj
);
  strobe_t           stb;
  logic [HOLD-1:0]   holdValid;
  logic [HOLD*TW-1:0] holdTag;

  cv_ctrl u_ctrl (
    .mode(mode), .resValid(resValid), .resTag(resTag), .cfgEn(cfgEn),
    .cfgSrc(cfgSrc), .cfgIdx(cfgIdx), .storeEn(storeEn), .storeIdx(storeIdx),
    .holdValid(holdValid), .holdTag(holdTag), .stb(stb)
  );

  cv_dpath u_dpath (
    .clk(clk), .rst(rst), .mode(mode), .resValid(resValid), .resData(resData),
    .resTag(resTag), .cfgSrc(cfgSrc), .cfgIdx(cfgIdx), .storeEn(storeEn),
    .storeIdx(storeIdx), .stb(stb), .holdValid(holdValid), .holdTag(holdTag),
    .cmtValid(cmtValid), .cmtData(cmtData), .cmtTag(cmtTag), .cmtErr(cmtErr),
    .cmtNoMaj(cmtNoMaj)
  );
endmodule

// File: rtl/cv_checker.sv
`timescale 1ns/1ps
module cv_checker import cv_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              mode,
  input logic [VOTERS-1:0] cfgEn,
  input logic [VOTERS-1:0] cmtValid,
  input logic [VOTERS-1:0] cmtErr,
  input logic [VOTERS-1:0] cmtNoMaj
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmtValid == '0 && cmtErr == '0 && cmtNoMaj == '0));

  a_r5_nomaj_has_err: assert property (@(posedge clk) disable iff (rst)
    (cmtNoMaj & ~cmtErr) == '0);

  a_r8_flags_need_commit: assert property (@(posedge clk) disable iff (rst)
    ((cmtErr | cmtNoMaj) & ~cmtValid) == '0);

  a_r9_commit_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (cmtValid != '0) |-> ((cmtValid & ~$past(cfgEn)) == '0));

  a_r11_pair_no_nomaj: assert property (@(posedge clk) disable iff (rst)
    (cmtNoMaj != '0) |-> $past(mode));
endmodule

bind commit_voter cv_checker u_chk (
  .clk(clk), .rst(rst), .mode(mode), .cfgEn(cfgEn),
  .cmtValid(cmtValid), .cmtErr(cmtErr), .cmtNoMaj(cmtNoMaj)
);

// File: tb/commit_voter_bench.sv
`timescale 1ns/1ps
module commit_voter_bench;
  import cv_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic [SLOTS-1:0]              resValid = '0;
  logic [SLOTS*DW-1:0]           resData  = '0;
  logic [SLOTS*TW-1:0]           resTag   = '0;
  logic [VOTERS-1:0]             cfgEn    = '0;
  logic [VOTERS*COPIES-1:0]      cfgSrc   = '0;
  logic [VOTERS*COPIES*IDXW-1:0] cfgIdx   = '0;
  logic [SLOTS-1:0]              storeEn  = '0;
  logic [SLOTS*IDXW-1:0]         storeIdx = '0;
  logic [VOTERS-1:0]             cmtValid;
  logic [VOTERS*DW-1:0]          cmtData;
  logic [VOTERS*TW-1:0]          cmtTag;
  logic [VOTERS-1:0]             cmtErr;
  logic [VOTERS-1:0]             cmtNoMaj;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  bit            mV [HOLD];
  logic [DW-1:0] mD [HOLD];
  logic [TW-1:0] mT [HOLD];

  always #2.5 clk = ~clk;

  commit_voter u_commit_voter (
    .clk(clk), .rst(rst), .mode(mode), .resValid(resValid), .resData(resData),
    .resTag(resTag), .cfgEn(cfgEn), .cfgSrc(cfgSrc), .cfgIdx(cfgIdx),
    .storeEn(storeEn), .storeIdx(storeIdx), .cmtValid(cmtValid),
    .cmtData(cmtData), .cmtTag(cmtTag), .cmtErr(cmtErr), .cmtNoMaj(cmtNoMaj)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      total++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    resValid = '0; resData = '0; resTag = '0;
    cfgEn = '0; cfgSrc = '0; cfgIdx = '0; storeEn = '0; storeIdx = '0;
  endtask

  task automatic setRes(input int s, input logic [DW-1:0] d, input logic [TW-1:0] t);
    resValid[s] = 1'b1;
    resData[s*DW +: DW] = d;
    resTag[s*TW +: TW]  = t;
  endtask

  task automatic setCopy(input int v, input int c, input bit src, input int idx);
    cfgSrc[v*COPIES+c] = src;
    cfgIdx[(v*COPIES+c)*IDXW +: IDXW] = IDXW'(idx);
  endtask

  task automatic setStore(input int s, input int h);
    storeEn[s] = 1'b1;
    storeIdx[s*IDXW +: IDXW] = IDXW'(h);
  endtask

  // expected vote from the requirement text
  task automatic vote(input bit m, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [DW-1:0] c, output logic [DW-1:0] v,
                      output bit e, output bit n);
    if (!m) begin
      v = a; e = (a != b); n = 1'b0;
    end else begin
      if (a == b || a == c) v = a;
      else if (b == c) v = b;
      else v = a;
      e = !(a == b && b == c);
      n = (a != b) && (a != c) && (b != c);
    end
  endtask

  task automatic step(input string req);
    bit            eV [VOTERS];
    logic [DW-1:0] eD [VOTERS];
    logic [TW-1:0] eT [VOTERS];
    bit            eE [VOTERS];
    bit            eN [VOTERS];
    bit            nV [HOLD];
    logic [DW-1:0] nD [HOLD];
    logic [TW-1:0] nT [HOLD];
    for (int h = 0; h < HOLD; h++) begin
      nV[h] = mV[h]; nD[h] = mD[h]; nT[h] = mT[h];
    end
    for (int v = 0; v < VOTERS; v++) begin
      logic [DW-1:0] cd [COPIES];
      logic [TW-1:0] ct [COPIES];
      int n;
      bit ok;
      n  = mode ? 3 : 2;
      ok = cfgEn[v];
      for (int c = 0; c < COPIES; c++) begin
        int k, idx;
        bit p;
        k   = v*COPIES + c;
        idx = int'(cfgIdx[k*IDXW +: IDXW]);
        if (cfgSrc[k]) begin
          p = mV[idx]; cd[c] = mD[idx]; ct[c] = mT[idx];
        end else begin
          p = resValid[idx]; cd[c] = resData[idx*DW +: DW]; ct[c] = resTag[idx*TW +: TW];
        end
        if (c < n && (!p || ct[c] != ct[0])) ok = 1'b0;
      end
      eV[v] = ok; eD[v] = '0; eT[v] = '0; eE[v] = 0; eN[v] = 0;
      if (ok) begin
        vote(mode, cd[0], cd[1], cd[2], eD[v], eE[v], eN[v]);
        eT[v] = ct[0];
        for (int c = 0; c < n; c++)
          if (cfgSrc[v*COPIES+c]) nV[int'(cfgIdx[(v*COPIES+c)*IDXW +: IDXW])] = 1'b0;
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (storeEn[s] && resValid[s]) begin
        int h;
        h = int'(storeIdx[s*IDXW +: IDXW]);
        nV[h] = 1'b1; nD[h] = resData[s*DW +: DW]; nT[h] = resTag[s*TW +: TW];
      end
    end
    @(posedge clk); #1;
    for (int v = 0; v < VOTERS; v++) begin
      chk(cmtValid[v] == eV[v], req, "valid", cmtValid[v], eV[v]);
      chk(cmtErr[v] == eE[v], req, "err", cmtErr[v], eE[v]);
      chk(cmtNoMaj[v] == eN[v], req, "noMaj", cmtNoMaj[v], eN[v]);
      if (eV[v]) begin
        chk(cmtData[v*DW +: DW] == eD[v], req, "data", cmtData[v*DW +: DW], eD[v]);
        chk(cmtTag[v*TW +: TW] == eT[v], req, "tag", cmtTag[v*TW +: TW], eT[v]);
      end
    end
    for (int h = 0; h < HOLD; h++) begin
      mV[h] = nV[h]; mD[h] = nD[h]; mT[h] = nT[h];
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int h = 0; h < HOLD; h++) begin
      mV[h] = 0; mD[h] = '0; mT[h] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: outputs cleared after reset
    chk(cmtValid == '0 && cmtErr == '0 && cmtNoMaj == '0, "R1", "reset outputs",
        {cmtValid, cmtErr, cmtNoMaj}, 0);
    // R1: empty holding store cannot feed a commit
    clearIn(); mode = 0; cfgEn = 2'b01;
    setCopy(0, 0, 1, 0); setCopy(0, 1, 1, 1);
    step("R1");
    chk(cmtValid[0] == 1'b0, "R1", "hold empty after reset", cmtValid[0], 0);

    // R2 R9: pair agrees
    clearIn(); mode = 0; cfgEn = 2'b01;
    setRes(0, 16'h0005, 4'h3); setRes(1, 16'h0005, 4'h3);
    setCopy(0, 0, 0, 0); setCopy(0, 1, 0, 1);
    step("R2");
    chk(cmtValid[0] && cmtData[15:0] == 16'h0005 && !cmtErr[0], "R2", "pair commit",
        cmtData[15:0], 16'h0005);

    // R3: pair disagrees
    clearIn(); mode = 0; cfgEn = 2'b10;
    setRes(2, 16'h0005, 4'h1); setRes(3, 16'h0006, 4'h1);
    setCopy(1, 0, 0, 2); setCopy(1, 1, 0, 3);
    step("R3");
    chk(cmtErr[1] && cmtData[31:16] == 16'h0005, "R3", "pair mismatch", cmtData[31:16], 16'h0005);

    // R4: two-of-three, majority on copies 0 and 2, and on copies 1 and 2
    clearIn(); mode = 1; cfgEn = 2'b11;
    setRes(0, 16'h0007, 4'h2); setRes(1, 16'h0009, 4'h2); setRes(2, 16'h0007, 4'h2);
    setCopy(0, 0, 0, 0); setCopy(0, 1, 0, 1); setCopy(0, 2, 0, 2);
    setCopy(1, 0, 0, 1); setCopy(1, 1, 0, 0); setCopy(1, 2, 0, 2);
    step("R4");
    chk(cmtData[15:0] == 16'h0007 && cmtData[31:16] == 16'h0007 && cmtErr == 2'b11 &&
        cmtNoMaj == 2'b00, "R4", "majority", cmtData, 32'h00070007);

    // R5: all three differ
    clearIn(); mode = 1; cfgEn = 2'b01;
    setRes(0, 16'h0001, 4'h4); setRes(1, 16'h0002, 4'h4); setRes(2, 16'h0003, 4'h4);
    setCopy(0, 0, 0, 0); setCopy(0, 1, 0, 1); setCopy(0, 2, 0, 2);
    step("R5");
    chk(cmtNoMaj[0] && cmtErr[0] && cmtData[15:0] == 16'h0001, "R5", "no majority",
        cmtData[15:0], 16'h0001);

    // R6: park, then pair with later partner
    clearIn(); mode = 0;
    setRes(0, 16'h0011, 4'h2); setStore(0, 1);
    step("R6");
    clearIn(); mode = 0; cfgEn = 2'b01;
    setRes(2, 16'h0011, 4'h2);
    setCopy(0, 0, 1, 1); setCopy(0, 1, 0, 2);
    step("R6");
    chk(cmtValid[0] && cmtData[15:0] == 16'h0011 && !cmtErr[0], "R6", "held pair",
        cmtData[15:0], 16'h0011);
    // R7: entry consumed, same selection again does not commit
    step("R7");
    chk(!cmtValid[0], "R7", "consumed entry", cmtValid[0], 0);

    // R8: three-way with an empty third copy, and a tag mismatch
    clearIn(); mode = 1; cfgEn = 2'b11;
    setRes(0, 16'h0004, 4'h1); setRes(1, 16'h0004, 4'h1); setRes(2, 16'h0004, 4'h2);
    setCopy(0, 0, 0, 0); setCopy(0, 1, 0, 1); setCopy(0, 2, 1, 3);
    setCopy(1, 0, 0, 0); setCopy(1, 1, 0, 1); setCopy(1, 2, 0, 2);
    step("R8");
    chk(cmtValid == 2'b00, "R8", "partial or tag mismatch", cmtValid, 0);

    // R8: partial set keeps its held entry
    clearIn(); mode = 1;
    setRes(3, 16'h0021, 4'h5); setStore(3, 2);
    step("R8");
    clearIn(); mode = 1; cfgEn = 2'b01;
    setRes(0, 16'h0021, 4'h5);
    setCopy(0, 0, 1, 2); setCopy(0, 1, 0, 0); setCopy(0, 2, 0, 1);
    step("R8");
    clearIn(); mode = 1; cfgEn = 2'b01;
    setRes(0, 16'h0021, 4'h5); setRes(1, 16'h0021, 4'h5);
    setCopy(0, 0, 1, 2); setCopy(0, 1, 0, 0); setCopy(0, 2, 0, 1);
    step("R8");
    chk(cmtValid[0] && !cmtErr[0], "R8", "entry kept until complete", cmtValid[0], 1);

    // R11: pair mode ignores third copy pointing at nothing
    clearIn(); mode = 0; cfgEn = 2'b10;
    setRes(1, 16'h0033, 4'h6); setRes(3, 16'h0033, 4'h6);
    setCopy(1, 0, 0, 1); setCopy(1, 1, 0, 3); setCopy(1, 2, 1, 0);
    step("R11");
    chk(cmtValid[1] && !cmtNoMaj[1], "R11", "third copy ignored", cmtValid[1], 1);

    // R10: consume and refill the same entry in one cycle
    clearIn(); mode = 0;
    setRes(0, 16'h0040, 4'h7); setStore(0, 0);
    step("R10");
    clearIn(); mode = 0; cfgEn = 2'b01;
    setRes(1, 16'h0040, 4'h7); setRes(2, 16'h0050, 4'h8); setStore(2, 0);
    setCopy(0, 0, 1, 0); setCopy(0, 1, 0, 1);
    step("R10");
    clearIn(); mode = 0; cfgEn = 2'b01;
    setRes(3, 16'h0050, 4'h8);
    setCopy(0, 0, 1, 0); setCopy(0, 1, 0, 3);
    step("R10");
    chk(cmtValid[0] && cmtData[15:0] == 16'h0050 && cmtTag[3:0] == 4'h8, "R10",
        "write wins over clear", cmtData[15:0], 16'h0050);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 3000; i++) begin
      int off;
      clearIn();
      mode = 1'($urandom % 2);
      off  = int'($urandom % HOLD);
      for (int s = 0; s < SLOTS; s++) begin
        if ($urandom % 4 != 0) setRes(s, DW'($urandom % 4), TW'($urandom % 2));
        if ($urandom % 4 == 0) setStore(s, (s + off) % HOLD);
      end
      cfgEn = VOTERS'($urandom);
      for (int v = 0; v < VOTERS; v++)
        for (int c = 0; c < COPIES; c++)
          setCopy(v, c, 1'($urandom % 2), int'($urandom % SLOTS));
      step("R9");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule